// File: doc/BRIEF.md
# Multiplexed LCD Segment Scan Controller

This block holds the on/off bit-map of a four-common multiplexed LCD and scans it at 1/4 duty. A 16-byte display memory is filled through a synchronous write port and can be read back at any time. An external frame-rate tick, running at four times the frame rate, steps the active common. For each common the block presents a one-hot common-select vector and a 20-bit segment state vector. The default tick rate is 320 Hz, which gives an 80 Hz frame. Bias generation, analog drive waveforms, the host serial link and the oscillator belong to other blocks.

Each memory byte serves a pair of neighbouring segments. The low nibble holds the even segment and the high nibble holds the odd one. Within a nibble, bit k belongs to common k. A display-enable bit and a blink-enable bit are loaded through a configuration strobe, and both are cleared by reset. For a programmed number of clock cycles after reset the block reports busy and discards every host write.

Top module: `lcdscan_top`

## Requirements
- R1: While reset is asserted and immediately after it, busy is 1, comSel is 0 and segOn is 0, because display and blink both start disabled.
- R2: After reset is released, busy stays 1 for exactly BUSY_CYCLES clock cycles. While busy is 1, memory writes and configuration writes are discarded. A byte written during that time reads back as 0, and the display stays off.
- R3: The memory holds 16 bytes at addresses 0h to Fh, and all of them can be written and read. rdData always shows the byte at rdAddr.
- R4: Each clock cycle with frameTick high advances the active common in the order 0, 1, 2, 3, 0. With the display on, comSel is one-hot with bit k set for common k. Four ticks make one frame.
- R5: For address n from 0 to 9, segOn[2n] equals bit p of byte n and segOn[2n+1] equals bit 4+p of byte n, where p is the active common. A 1 means the segment is on.
- R6: With the display disabled, comSel and segOn are both 0 whatever the memory holds. Common stepping continues in the background.
- R7: A memory write reaches segOn only at the next phase boundary, which is a frameTick cycle. Between boundaries segOn does not change.
- R8: With blink enabled, segOn is forced to 0 during alternate periods of BLINK_TICKS frame ticks. The first period after blink is enabled is lit. comSel keeps scanning throughout.
- R9: Bytes at addresses Ah to Fh have no effect on segOn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameTick | input | 1 | One-cycle pulse at four times the frame rate |
| wrEn | input | 1 | Memory write strobe |
| wrAddr | input | 4 | Memory write address |
| wrData | input | 8 | Memory write byte |
| rdAddr | input | 4 | Memory read address |
| rdData | output | 8 | Byte stored at rdAddr |
| cfgWr | input | 1 | Load the display and blink enables |
| cfgDispOn | input | 1 | Display enable value to load |
| cfgBlinkOn | input | 1 | Blink enable value to load |
| busy | output | 1 | Post-reset hold-off; writes are discarded while high |
| comSel | output | 4 | One-hot active common |
| segOn | output | 20 | Segment on/off state for the active common |

## Verification
Several properties are checked by assertions on every cycle. comSel is never more than one-hot, and each tick advances the phase by exactly one. No memory write strobe reaches the datapath while busy is high. The latched segment vector holds between ticks, and segOn is 0 whenever the display is off. The bench scenarios cover the rest. They show the nibble-and-bit mapping from memory to segments across several byte patterns, the exact length of the busy window, and that writes made while busy are lost. They also show the lit and dark periods of blink and that addresses Ah to Fh do not reach the outputs.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;
  localparam int COM_COUNT = 4;
  localparam int PHASE_W   = $clog2(COM_COUNT);

  typedef logic [PHASE_W-1:0] phase_t;

  typedef struct packed {
    logic   advance;
    phase_t nextPhase;
    logic   memWe;
    logic   showSeg;
  } scanStrobes_t;
endpackage

// File: rtl/lcdscan_ctrl.sv
module lcdscan_ctrl
  import lcdscan_pkg::*;
#(
  parameter int BUSY_CYCLES = 50000,
  parameter int BLINK_TICKS = 160
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameTick,
  input  logic                 wrEn,
  input  logic                 cfgWr,
  input  logic                 cfgDispOn,
  input  logic                 cfgBlinkOn,
  output logic                 busy,
  output logic [COM_COUNT-1:0] comSel,
  output scanStrobes_t         strb
);
  localparam int BUSY_W  = $clog2(BUSY_CYCLES + 1);
  localparam int BLINK_W = $clog2(BLINK_TICKS);

  logic [BUSY_W-1:0]  busyCnt;
  logic [BLINK_W-1:0] blinkCnt;
  logic               dispOnQ, blinkOnQ, darkQ;
  phase_t             phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b1;
      busyCnt <= '0;
    end else if (busy) begin
      if (busyCnt == BUSY_W'(BUSY_CYCLES - 1)) busy <= 1'b0;
      busyCnt <= busyCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispOnQ  <= 1'b0;
      blinkOnQ <= 1'b0;
    end else if (cfgWr && !busy) begin
      dispOnQ  <= cfgDispOn;
      blinkOnQ <= cfgBlinkOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else if (frameTick) phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !blinkOnQ) begin
      blinkCnt <= '0;
      darkQ    <= 1'b0;
    end else if (frameTick) begin
      if (blinkCnt == BLINK_W'(BLINK_TICKS - 1)) begin
        blinkCnt <= '0;
        darkQ    <= !darkQ;
      end else begin
        blinkCnt <= blinkCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.advance   = frameTick;
    strb.nextPhase = phase + 1'b1;
    strb.memWe     = wrEn && !busy;
    strb.showSeg   = dispOnQ && !(blinkOnQ && darkQ);
    comSel         = '0;
    if (dispOnQ) comSel[phase] = 1'b1;
  end

  a_r4_onehot_com: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comSel));
  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    frameTick |=> phase == $past(phase) + 1'b1);
  a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameTick |=> $stable(phase));
endmodule

// File: rtl/lcdscan_dp.sv
module lcdscan_dp
  import lcdscan_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WIDTH     = 8,
  parameter int SEG_COUNT = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scanStrobes_t             strb,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [WIDTH-1:0]         wrData,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic [WIDTH-1:0]         rdData,
  output logic [SEG_COUNT-1:0]     segOn
);
  localparam int PAIRS = SEG_COUNT / 2;
  localparam int BIT_W = $clog2(WIDTH);

  logic [WIDTH-1:0]     mem [DEPTH];
  logic [SEG_COUNT-1:0] segQ, segNext;
  logic [BIT_W-1:0]     loIdx, hiIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.memWe) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdData = mem[rdAddr];

  always_comb begin
    loIdx = BIT_W'(strb.nextPhase);
    hiIdx = BIT_W'(COM_COUNT) + BIT_W'(strb.nextPhase);
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    assign segNext[2*g]   = mem[g][loIdx];
    assign segNext[2*g+1] = mem[g][hiIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) segQ <= '0;
    else if (strb.advance) segQ <= segNext;
  end

  assign segOn = strb.showSeg ? segQ : '0;

  a_r7_seg_latched: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(segQ));
endmodule

// File: rtl/lcdscan_top.sv
module lcdscan_top
  import lcdscan_pkg::*;
#(
  parameter int BUSY_CYCLES = 50000,
  parameter int BLINK_TICKS = 160
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameTick,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [3:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        cfgWr,
  input  logic        cfgDispOn,
  input  logic        cfgBlinkOn,
  output logic        busy,
  output logic [3:0]  comSel,
  output logic [19:0] segOn
);
  scanStrobes_t strb;

  lcdscan_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .BLINK_TICKS(BLINK_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .wrEn(wrEn),
    .cfgWr(cfgWr), .cfgDispOn(cfgDispOn), .cfgBlinkOn(cfgBlinkOn),
    .busy(busy), .comSel(comSel), .strb(strb)
  );

  lcdscan_dp #(.DEPTH(16), .WIDTH(8), .SEG_COUNT(20)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .segOn(segOn)
  );

  a_r2_no_write_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.memWe);
  a_r6_dark_when_off: assert property (@(posedge clk) disable iff (!rstN)
    comSel == '0 |-> segOn == '0);
endmodule

// File: tb/lcdscan_top_tb_top.sv
module lcdscan_top_tb_top;
  localparam int BUSY = 8;
  localparam int BLNK = 4;
  localparam int NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'h0, 8'hA5}, {4'h1, 8'h3C}, {4'h4, 8'h81},
    {4'h7, 8'h5A}, {4'h9, 8'hF0}, {4'h2, 8'h0F}
  };

  logic clk = 0, rstN = 0, frameTick = 0, wrEn = 0, cfgWr = 0;
  logic cfgDispOn = 0, cfgBlinkOn = 0;
  logic [3:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic busy;
  logic [3:0] comSel;
  logic [19:0] segOn;

  int compared = 0, mismatched = 0;
  logic [7:0] model [16];
  logic [1:0] phaseModel = 0;
  logic [19:0] expSnap = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lcdscan_top #(.BUSY_CYCLES(BUSY), .BLINK_TICKS(BLNK)) dut_i (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .cfgWr(cfgWr), .cfgDispOn(cfgDispOn), .cfgBlinkOn(cfgBlinkOn),
    .busy(busy), .comSel(comSel), .segOn(segOn)
  );

  function automatic logic [19:0] calcSeg(logic [1:0] p);
    logic [19:0] s;
    for (int n = 0; n < 10; n++) begin
      s[2*n]   = model[n][p];
      s[2*n+1] = model[n][4+p];
    end
    return s;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeMem(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
    model[a] = d;
  endtask

  task automatic setCfg(logic d, logic b);
    @(negedge clk); cfgWr = 1; cfgDispOn = d; cfgBlinkOn = b;
    @(negedge clk); cfgWr = 0;
  endtask

  task automatic tick();
    @(negedge clk); frameTick = 1;
    @(negedge clk); frameTick = 0;
    phaseModel = phaseModel + 1'b1;
    expSnap = calcSeg(phaseModel);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy), 1);
    chk("R1 comSel", 32'(comSel), 0);
    chk("R1 segOn", 32'(segOn), 0);
    rstN = 1;
    wrEn = 1; wrAddr = 4'h3; wrData = 8'h77;
    cfgWr = 1; cfgDispOn = 1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); n++;
      wrEn = 0; cfgWr = 0;
      if (!busy) break;
    end
    chk("R2 busy length", 32'(n), BUSY);
    rdAddr = 4'h3; #1;
    chk("R2 write during busy dropped", 32'(rdData), 0);
    chk("R2 cfg during busy dropped", 32'(comSel), 0);
    chk("R1 segOn after reset", 32'(segOn), 0);

    setCfg(1, 0);
    for (int v = 0; v < NVEC; v++) begin
      writeMem(VEC[v][11:8], VEC[v][7:0]);
      rdAddr = VEC[v][11:8]; #1;
      chk("R3 readback", 32'(rdData), 32'(VEC[v][7:0]));
      for (int t = 0; t < 4; t++) begin
        tick();
        chk("R4 comSel", 32'(comSel), 32'(4'b0001 << phaseModel));
        chk("R5 segOn", 32'(segOn), 32'(expSnap));
      end
    end

    writeMem(4'h0, model[0] ^ 8'hFF);
    chk("R7 no mid-phase change", 32'(segOn), 32'(expSnap));
    tick();
    chk("R7 applied at boundary", 32'(segOn), 32'(expSnap));

    for (int a = 10; a < 16; a++) begin
      writeMem(4'(a), 8'hFF);
      rdAddr = 4'(a); #1;
      chk("R3 upper readback", 32'(rdData), 32'hFF);
    end
    for (int t = 0; t < 4; t++) begin
      tick();
      chk("R9 upper unmapped", 32'(segOn), 32'(expSnap));
    end

    writeMem(4'h0, 8'hFF);
    setCfg(1, 1);
    for (int t = 1; t <= 2 * BLNK; t++) begin
      tick();
      chk("R8 comSel scanning", 32'(comSel), 32'(4'b0001 << phaseModel));
      if (t < BLNK || t == 2 * BLNK)
        chk("R8 lit period", 32'(segOn), 32'(expSnap));
      else
        chk("R8 dark period", 32'(segOn), 0);
    end

    setCfg(0, 0);
    chk("R6 comSel off", 32'(comSel), 0);
    chk("R6 segOn off", 32'(segOn), 0);
    tick();
    chk("R6 off after tick", 32'(segOn), 0);
    setCfg(1, 0);
    chk("R6 scan continued", 32'(comSel), 32'(4'b0001 << phaseModel));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule